// File: doc/BRIEF.md
# Display Column Latch with Blanking Override

This block sits behind a wide serial-to-parallel column loader in a flat-panel driver. It takes the loader's full parallel word and holds it in a capture register. A new word is taken only when the active-low load strobe goes from high to low. Between those strobe falls the held word does not change, whatever level the strobe sits at.

Three panel-control inputs act on the held word on its way to the column drivers. Their priority is fixed:

1. A float request releases every column.
2. Otherwise, a low on the active-low force-high input drives every column high.
3. Otherwise, a low on the active-low force-low input drives every column low.

When none of them is active, each column shows its own held bit.

Each column is presented as a value bit plus an output-enable bit, so a released column is simply "enable clear, value 0". The override path is purely combinational on the held word, so blanking acts within the same cycle and never disturbs the held data.

Top module: `col_latch_top`

## Requirements
- R1: A synchronous active-high reset clears the held word to all zeros. With no override active after reset, drv_val reads all zeros and drv_oe reads all ones.
- R2: The held word is loaded from par_data at the clock edge where strobe_n is sampled low and was sampled high at the previous edge. The new word is visible on drv_val right after that edge.
- R3: At every other edge the held word keeps its value, whether strobe_n stays low or stays high, and whatever par_data does.
- R4: When float_en is 1, every drv_oe bit is 0 and every drv_val bit is 0. This holds regardless of force_hi_n and force_lo_n.
- R5: When float_en is 0 and force_hi_n is 0, every drv_val bit and every drv_oe bit is 1, whatever force_lo_n is.
- R6: When float_en is 0, force_hi_n is 1 and force_lo_n is 0, every drv_val bit is 0 and every drv_oe bit is 1.
- R7: When float_en is 0 and both force inputs are 1, drv_val bit n equals held bit n and every drv_oe bit is 1.
- R8: Override inputs act on the outputs without waiting for a clock edge. Applying and then releasing any override leaves the held word unchanged.
- R9: Reset leaves the strobe history as "low". A strobe_n held low across reset release loads nothing until it has been sampled high and then falls again.
- R10: A strobe fall that happens while an override is active still loads the held word. The new word appears once the override is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_data | input | WIDTH | Parallel word from the column loader |
| strobe_n | input | 1 | Active-low load strobe; loads on its fall |
| force_hi_n | input | 1 | Active-low force of all columns high |
| force_lo_n | input | 1 | Active-low force of all columns low |
| float_en | input | 1 | Active-high release of all columns |
| drv_val | output | WIDTH | Column value bits |
| drv_oe | output | WIDTH | Column output-enable bits |

## Verification
The embedded assertions check four things on every cycle:
- the output pair against the override priority, for each of the four drive modes;
- that the held word changes only on a detected strobe fall, and then to the word on par_data;
- that reset clears the held word;
- that no two consecutive cycles both see a strobe fall.

Some behaviours only the bench scenarios can show. These are:
- that a strobe held low through reset loads nothing;
- that overrides act between clock edges;
- that a load made under an override surfaces after release.

The bench shows these by sweeping all eight override combinations over several data patterns and comparing against arithmetically computed words.

// File: rtl/col_latch_pkg.sv
package col_latch_pkg;

  typedef enum logic [1:0] {
    DRV_PASS  = 2'd0,
    DRV_LOW   = 2'd1,
    DRV_HIGH  = 2'd2,
    DRV_FLOAT = 2'd3
  } drv_mode_e;

  // Fixed priority: float over force-high over force-low over pass-through.
  function automatic drv_mode_e resolve_mode(input logic float_en,
                                             input logic force_hi_n,
                                             input logic force_lo_n);
    drv_mode_e m;
    if (float_en)         m = DRV_FLOAT;
    else if (!force_hi_n) m = DRV_HIGH;
    else if (!force_lo_n) m = DRV_LOW;
    else                  m = DRV_PASS;
    return m;
  endfunction

endpackage

// File: rtl/col_strobe_edge.sv
module col_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic load_pulse
);

  logic strobe_q;

  // History resets to "low" so a strobe held low through reset is not a fall.
  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe_n;
  end

  assign load_pulse = strobe_q & ~strobe_n;

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> !load_pulse); // R2

endmodule

// File: rtl/col_capture_reg.sv
module col_capture_reg #(
  parameter int WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_pulse,
  input  logic [WIDTH-1:0] par_data,
  output logic [WIDTH-1:0] held_q
);

  always_ff @(posedge clk) begin
    if (rst)             held_q <= '0;
    else if (load_pulse) held_q <= par_data;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> held_q == '0); // R1
  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> held_q == $past(par_data)); // R2
  AST_HOLD_WITHOUT_FALL: assert property (@(posedge clk) disable iff (rst)
    !load_pulse |=> $stable(held_q)); // R3

endmodule

// File: rtl/col_drive_override.sv
module col_drive_override
  import col_latch_pkg::*;
#(
  parameter int WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] held_q,
  input  logic             float_en,
  input  logic             force_hi_n,
  input  logic             force_lo_n,
  output logic [WIDTH-1:0] drv_val,
  output logic [WIDTH-1:0] drv_oe
);

  drv_mode_e mode;

  assign mode = resolve_mode(float_en, force_hi_n, force_lo_n);

  // One column cell per bit; every cell sees the same resolved mode.
  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    always_comb begin
      unique case (mode)
        DRV_FLOAT: begin drv_val[i] = 1'b0;      drv_oe[i] = 1'b0; end
        DRV_HIGH:  begin drv_val[i] = 1'b1;      drv_oe[i] = 1'b1; end
        DRV_LOW:   begin drv_val[i] = 1'b0;      drv_oe[i] = 1'b1; end
        default:   begin drv_val[i] = held_q[i]; drv_oe[i] = 1'b1; end
      endcase
    end
  end

  AST_FLOAT_RELEASES: assert property (@(posedge clk) disable iff (rst)
    float_en |-> (drv_oe == '0 && drv_val == '0)); // R4
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!float_en && !force_hi_n) |-> (&drv_val && &drv_oe)); // R5
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!float_en && force_hi_n && !force_lo_n) |-> (drv_val == '0 && &drv_oe)); // R6
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (!float_en && force_hi_n && force_lo_n) |-> (drv_val == held_q && &drv_oe)); // R7

endmodule

// File: rtl/col_latch_top.sv
module col_latch_top #(
  parameter int WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_data,
  input  logic             strobe_n,
  input  logic             force_hi_n,
  input  logic             force_lo_n,
  input  logic             float_en,
  output logic [WIDTH-1:0] drv_val,
  output logic [WIDTH-1:0] drv_oe
);

  logic             load_pulse;
  logic [WIDTH-1:0] held_q;

  col_strobe_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .strobe_n   (strobe_n),
    .load_pulse (load_pulse)
  );

  col_capture_reg #(.WIDTH(WIDTH)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .load_pulse (load_pulse),
    .par_data   (par_data),
    .held_q     (held_q)
  );

  col_drive_override #(.WIDTH(WIDTH)) u_ovr (
    .clk        (clk),
    .rst        (rst),
    .held_q     (held_q),
    .float_en   (float_en),
    .force_hi_n (force_hi_n),
    .force_lo_n (force_lo_n),
    .drv_val    (drv_val),
    .drv_oe     (drv_oe)
  );

endmodule

// File: tb/col_latch_top_tb_top.sv
module col_latch_top_tb_top;

  localparam int W = 96;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] par_data = '0;
  logic         strobe_n = 1'b0;
  logic         force_hi_n = 1'b1;
  logic         force_lo_n = 1'b1;
  logic         float_en = 1'b0;
  logic [W-1:0] drv_val;
  logic [W-1:0] drv_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  col_latch_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .par_data(par_data), .strobe_n(strobe_n),
    .force_hi_n(force_hi_n), .force_lo_n(force_lo_n), .float_en(float_en),
    .drv_val(drv_val), .drv_oe(drv_oe)
  );

  task automatic check(input string req, input logic [W-1:0] ev, input logic [W-1:0] eo);
    n_cmp++;
    if (drv_val !== ev || drv_oe !== eo) begin
      n_bad++;
      $display("FAIL %s val=%h exp_val=%h oe=%h exp_oe=%h", req, drv_val, ev, drv_oe, eo);
    end
  endtask

  // Load a word: strobe high for one edge, then low; sample after the capturing edge.
  task automatic load_word(input logic [W-1:0] d);
    @(negedge clk); par_data = d; strobe_n = 1'b1;
    @(negedge clk); strobe_n = 1'b0;
    @(negedge clk);
  endtask

  // Expected outputs derived from the priority rules in R4..R7.
  task automatic expect_mode(input logic fl, input logic hn, input logic ln,
                             input logic [W-1:0] held,
                             output logic [W-1:0] ev, output logic [W-1:0] eo,
                             output string req);
    if (fl)       begin ev = '0;   eo = '0; req = "R4"; end
    else if (!hn) begin ev = '1;   eo = '1; req = "R5"; end
    else if (!ln) begin ev = '0;   eo = '1; req = "R6"; end
    else          begin ev = held; eo = '1; req = "R7"; end
  endtask

  initial begin
    logic [W-1:0] pats [4];
    logic [W-1:0] ev, eo;
    string req;

    pats[0] = {3{32'hA5C3_0F96}};
    pats[1] = {W{1'b1}};
    pats[2] = {48{2'b01}};
    pats[3] = {{(W-1){1'b0}}, 1'b1} << (W-1);

    // R1 / R9: strobe held low through reset, data non-zero.
    par_data = pats[0];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", '0, '1);
    repeat (3) @(negedge clk);
    check("R9", '0, '1);

    // R2: a true fall loads the word.
    load_word(pats[0]);
    check("R2", pats[0], '1);

    // R3: strobe stays low, data moves.
    par_data = pats[1];
    repeat (3) @(negedge clk);
    check("R3", pats[0], '1);
    // R3: strobe high, data moves again.
    strobe_n = 1'b1; par_data = pats[2];
    repeat (3) @(negedge clk);
    check("R3", pats[0], '1);

    // Sweep every override combination over each pattern, between clock edges.
    for (int p = 0; p < 4; p++) begin
      load_word(pats[p]);
      check("R2", pats[p], '1);
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        #1;
        float_en = c[2]; force_hi_n = c[1]; force_lo_n = c[0];
        #1;   // R8: no clock edge between drive and sample
        expect_mode(c[2], c[1], c[0], pats[p], ev, eo, req);
        check(req, ev, eo);
        check("R8", ev, eo);
      end
      @(negedge clk);
      float_en = 1'b0; force_hi_n = 1'b1; force_lo_n = 1'b1;
      #1;
      check("R8", pats[p], '1);
    end

    // Walking one through several positions.
    for (int k = 0; k < W; k += 13) begin
      load_word({{(W-1){1'b0}}, 1'b1} << k);
      check("R2", {{(W-1){1'b0}}, 1'b1} << k, '1);
    end

    // R10: load while floating, surfaces after release.
    @(negedge clk); float_en = 1'b1;
    load_word(pats[2]);
    check("R4", '0, '0);
    @(negedge clk); float_en = 1'b0;
    #1;
    check("R10", pats[2], '1);

    // R10: load while forced high.
    @(negedge clk); force_hi_n = 1'b0;
    load_word(pats[3]);
    check("R5", '1, '1);
    @(negedge clk); force_hi_n = 1'b1;
    #1;
    check("R10", pats[3], '1);

    // R1: reset again clears a loaded word.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1", '0, '1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog val=%h exp_val=done oe=%h exp_oe=done", drv_val, drv_oe);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule